// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line in one private write-back cache that sits on a shared snooping bus with other caches. A small direct-mapped tag and state array sits inside it. The processor side presents a read or write request and holds it until the controller reports completion. The controller reports either a hit resolved without the bus, or a completion that followed one or more bus transactions that it issued. On the snoop side it sees the transactions that other caches place on the bus. In the same cycle it answers with a wired-OR shared indication and a flush request for a dirty line, and it updates the line's state.

A fourth state, exclusive-clean, is chosen when a read miss sees the shared line low. A later write to that line then completes locally. Dirty victims are written back before the replacing block is fetched, and snoops win over a processor request that arrives in the same cycle. Data storage, bus arbitration and memory are outside the block: the bus reports completion of an issued transaction on `bus_done`, together with the sampled shared line.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: no snoop sees a copy, and every processor access misses.
- R2: A read that hits a valid line with a matching tag completes in the request cycle. A read miss issues a bus read (command code 0) for the requested address. On its completion the line becomes Exclusive if `bus_shared_in` is 0 and Shared if it is 1.
- R3: A write that hits a line in Exclusive or Modified completes in the request cycle with no bus transaction, and the line becomes Modified.
- R4: A write to a line in Shared, or a write that misses, issues a read-for-ownership (command code 1) for the requested address. The line ends in Modified, and no completion is reported while the transaction is outstanding.
- R5: A snooped bus read (code 0) that hits a Modified line raises `snp_flush` and `snp_shared` in that cycle, and the line becomes Shared.
- R6: A snooped bus read that hits any valid copy raises `snp_shared`. A hit on an Exclusive line moves it to Shared without a flush.
- R7: A snooped read-for-ownership (code 1) that hits a valid line makes it Invalid. `snp_flush` is raised only when the line was Modified.
- R8: A miss whose indexed line holds a different block in Modified first issues a write-back (code 2) for the victim's address; the line becomes Invalid on its completion, and only then is the new block requested. A clean victim is replaced with no write-back.
- R9: While `snp_valid` is high, no processor request completes. The request is evaluated again, against the updated state, in a later cycle.
- R10: `cpu_hit` is high with `cpu_done` only for a request that completed without any bus transaction of its own.
- R11: A snooped write-back (code 2) changes no state and raises neither `snp_shared` nor `snp_flush`.
- R12: While a transaction is outstanding, `bus_valid`, `bus_cmd` and `bus_addr` hold steady until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until done |
| cpu_write | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | ADDR_W | Block address {tag, index} |
| cpu_done | output | 1 | Request completed this cycle |
| cpu_hit | output | 1 | Completion needed no bus transaction |
| bus_valid | output | 1 | Bus transaction outstanding |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 write-back |
| bus_addr | output | ADDR_W | Block address of the transaction |
| bus_done | input | 1 | Outstanding transaction has finished |
| bus_shared_in | input | 1 | Wired-OR shared line sampled at completion |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_shared | output | 1 | This cache drives the shared line |
| snp_flush | output | 1 | This cache must put its dirty line on the bus |

## Verification
The bench builds the block with ADDR_W=6 and INDEX_W=2, so four lines and sixteen tags. Random addresses are drawn from only sixteen blocks, which keeps index conflicts frequent. Dirty victims, write-back before refill, and snoops that land on a victim while its write-back is still outstanding therefore all occur in a few thousand cycles. With four lines, every state of every line also comes up repeatedly under snoop reads, read-for-ownership and ignored write-backs.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   localparam logic [1:0] ST_I = 2'd0;
   localparam logic [1:0] ST_S = 2'd1;
   localparam logic [1:0] ST_E = 2'd2;
   localparam logic [1:0] ST_M = 2'd3;

   localparam logic [1:0] CMD_RD  = 2'd0;
   localparam logic [1:0] CMD_RDX = 2'd1;
   localparam logic [1:0] CMD_WB  = 2'd2;
endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array #(
   parameter int INDEX_W = 2,
   parameter int TAG_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] a_idx,
   output logic [TAG_W-1:0]   a_tag,
   output logic [1:0]         a_st,
   input  logic [INDEX_W-1:0] b_idx,
   output logic [TAG_W-1:0]   b_tag,
   output logic [1:0]         b_st,
   input  logic               we,
   input  logic [INDEX_W-1:0] w_idx,
   input  logic [TAG_W-1:0]   w_tag,
   input  logic [1:0]         w_st
);
   localparam int LINES = 1 << INDEX_W;

   logic [TAG_W-1:0] tag_q [LINES];
   logic [1:0]       st_q  [LINES];

   for (genvar gi = 0; gi < LINES; gi++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[gi]  <= mesi_pkg::ST_I;
            tag_q[gi] <= '0;
         end else if (we && (w_idx == INDEX_W'(gi))) begin
            st_q[gi]  <= w_st;
            tag_q[gi] <= w_tag;
         end
      end
   end

   assign a_tag = tag_q[a_idx];
   assign a_st  = st_q[a_idx];
   assign b_tag = tag_q[b_idx];
   assign b_st  = st_q[b_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp (
   input  logic       snp_valid,
   input  logic [1:0] snp_cmd,
   input  logic       tag_match,
   input  logic [1:0] cur_st,
   output logic       shared_o,
   output logic       flush_o,
   output logic       upd_o,
   output logic [1:0] nxt_st
);
   import mesi_pkg::*;
   logic held;

   always_comb begin
      held     = snp_valid && tag_match && (cur_st != ST_I);
      shared_o = 1'b0;
      flush_o  = 1'b0;
      upd_o    = 1'b0;
      nxt_st   = cur_st;
      if (held) begin
         unique case (snp_cmd)
            CMD_RD: begin
               shared_o = 1'b1;
               flush_o  = (cur_st == ST_M);
               upd_o    = (cur_st != ST_S);
               nxt_st   = ST_S;
            end
            CMD_RDX: begin
               flush_o  = (cur_st == ST_M);
               upd_o    = 1'b1;
               nxt_st   = ST_I;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm #(
   parameter int ADDR_W  = 6,
   parameter int INDEX_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_valid,
   input  logic                      cpu_write,
   input  logic [ADDR_W-1:0]         cpu_addr,
   input  logic                      snp_valid,
   input  logic [ADDR_W-INDEX_W-1:0] line_tag,
   input  logic [1:0]                line_st,
   input  logic                      bus_done,
   input  logic                      bus_shared_in,
   output logic                      cpu_done,
   output logic                      cpu_hit,
   output logic                      bus_valid,
   output logic [1:0]                bus_cmd,
   output logic [ADDR_W-1:0]         bus_addr,
   output logic                      we,
   output logic [INDEX_W-1:0]        w_idx,
   output logic [ADDR_W-INDEX_W-1:0] w_tag,
   output logic [1:0]                w_st
);
   import mesi_pkg::*;
   localparam int TAG_W = ADDR_W - INDEX_W;

   logic              busy_q, used_q;
   logic [1:0]        cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              look, hit, local_ok, start;
   logic [1:0]        start_cmd;
   logic [ADDR_W-1:0] start_addr;
   logic [INDEX_W-1:0] idx;
   logic [TAG_W-1:0]   tag;

   assign idx = cpu_addr[INDEX_W-1:0];
   assign tag = cpu_addr[ADDR_W-1:INDEX_W];

   always_comb begin
      look     = !busy_q && cpu_valid && !snp_valid;
      hit      = (line_st != ST_I) && (line_tag == tag);
      local_ok = hit && (!cpu_write || line_st[1]);
      start    = look && !local_ok;
      if (!hit && line_st == ST_M) begin
         start_cmd  = CMD_WB;
         start_addr = {line_tag, idx};
      end else begin
         start_cmd  = cpu_write ? CMD_RDX : CMD_RD;
         start_addr = cpu_addr;
      end
      cpu_done = look && local_ok;
      cpu_hit  = cpu_done && !used_q;
      we       = 1'b0;
      w_idx    = idx;
      w_tag    = tag;
      w_st     = ST_M;
      if (busy_q && bus_done) begin
         we    = 1'b1;
         w_idx = addr_q[INDEX_W-1:0];
         w_tag = addr_q[ADDR_W-1:INDEX_W];
         unique case (cmd_q)
            CMD_WB:  w_st = ST_I;
            CMD_RD:  w_st = bus_shared_in ? ST_S : ST_E;
            default: w_st = ST_M;
         endcase
      end else if (cpu_done && cpu_write) begin
         we = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         used_q <= 1'b0;
         cmd_q  <= CMD_RD;
         addr_q <= '0;
      end else begin
         if (start) begin
            busy_q <= 1'b1;
            used_q <= 1'b1;
            cmd_q  <= start_cmd;
            addr_q <= start_addr;
         end else if (busy_q && bus_done) begin
            busy_q <= 1'b0;
         end
         if (cpu_done) used_q <= 1'b0;
      end
   end

   assign bus_valid = busy_q;
   assign bus_cmd   = cmd_q;
   assign bus_addr  = addr_q;
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
   parameter int ADDR_W  = 16,
   parameter int INDEX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic              bus_valid,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_done,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush
);
   localparam int TAG_W = ADDR_W - INDEX_W;

   if (INDEX_W < 1 || INDEX_W > 8 || TAG_W < 1) begin : g_bad_cfg
      initial $fatal(1, "mesi_line_ctrl: INDEX_W must be 1..8 and below ADDR_W");
   end

   logic [TAG_W-1:0]   a_tag, b_tag, f_tag, w_tag;
   logic [1:0]         a_st, b_st, s_nxt, f_st, w_st;
   logic [INDEX_W-1:0] f_idx, w_idx;
   logic               f_we, s_upd, w_en;

   mesi_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .a_idx(cpu_addr[INDEX_W-1:0]), .a_tag(a_tag), .a_st(a_st),
      .b_idx(snp_addr[INDEX_W-1:0]), .b_tag(b_tag), .b_st(b_st),
      .we(w_en), .w_idx(w_idx), .w_tag(w_tag), .w_st(w_st)
   );

   mesi_snoop_resp u_snp (
      .snp_valid(snp_valid), .snp_cmd(snp_cmd),
      .tag_match(b_tag == snp_addr[ADDR_W-1:INDEX_W]), .cur_st(b_st),
      .shared_o(snp_shared), .flush_o(snp_flush), .upd_o(s_upd), .nxt_st(s_nxt)
   );

   mesi_req_fsm #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
      .snp_valid(snp_valid), .line_tag(a_tag), .line_st(a_st),
      .bus_done(bus_done), .bus_shared_in(bus_shared_in),
      .cpu_done(cpu_done), .cpu_hit(cpu_hit),
      .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .we(f_we), .w_idx(f_idx), .w_tag(f_tag), .w_st(f_st)
   );

   always_comb begin
      w_en  = f_we || s_upd;
      w_idx = f_we ? f_idx : snp_addr[INDEX_W-1:0];
      w_tag = f_we ? f_tag : b_tag;
      w_st  = f_we ? f_st  : s_nxt;
   end
endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic              cpu_done,
   input logic              cpu_hit,
   input logic              bus_valid,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_done,
   input logic              snp_valid,
   input logic [1:0]        snp_cmd,
   input logic              snp_shared,
   input logic              snp_flush
);
   AST_RD_FLUSH_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == 2'd0 && snp_flush) |-> snp_shared); // R5
   AST_NO_DONE_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_done); // R9
   AST_HIT_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> cpu_done); // R10
   AST_NO_DONE_WHILE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !cpu_done); // R4
   AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_cmd) && $stable(bus_addr))); // R12
   AST_WB_SNOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == 2'd2) |-> (!snp_shared && !snp_flush)); // R11
   AST_BUS_FROM_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_valid) |-> $past(cpu_valid)); // R2
endmodule

bind mesi_line_ctrl mesi_line_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_done(cpu_done),
   .cpu_hit(cpu_hit), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
   .bus_addr(bus_addr), .bus_done(bus_done), .snp_valid(snp_valid),
   .snp_cmd(snp_cmd), .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
   localparam int AW = 6;
   localparam int IW = 2;
   localparam int NL = 1 << IW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_valid = 0, cpu_write = 0, bus_done = 0, bus_shared_in = 0, snp_valid = 0;
   logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
   logic [1:0] snp_cmd = 2'd0;
   logic cpu_done, cpu_hit, bus_valid, snp_shared, snp_flush;
   logic [1:0] bus_cmd;
   logic [AW-1:0] bus_addr;

   always #5 clk = ~clk;

   mesi_line_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
      .cpu_addr(cpu_addr), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
      .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .bus_done(bus_done), .bus_shared_in(bus_shared_in), .snp_valid(snp_valid),
      .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_shared(snp_shared),
      .snp_flush(snp_flush)
   );

   int checks = 0, fails = 0, cyc = 0;
   // reference model: 0 I, 1 S, 2 E, 3 M
   logic [1:0] m_st [NL];
   logic [AW-IW-1:0] m_tag [NL];
   logic m_busy = 0, m_used = 0;
   logic [1:0] m_cmd = 0;
   logic [AW-1:0] m_addr = 0;
   logic op_act = 0, op_w = 0;
   logic [AW-1:0] op_a = 0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic string bus_tag(logic [1:0] c);
      return (c == 2'd2) ? "R8" : (c == 2'd1) ? "R4" : "R2";
   endfunction

   // one cycle: drive, compare against model, advance model
   task automatic step(input logic cv, input logic cw, input logic [AW-1:0] ca,
                       input logic sv, input logic [1:0] sc, input logic [AW-1:0] sa,
                       input logic bd, input logic bs, input string ctx);
      logic [1:0] s_st, c_st;
      logic s_hit, c_hit, e_sh, e_fl, e_done, ok;
      int ci, si;
      @(negedge clk);
      cpu_valid = cv; cpu_write = cw; cpu_addr = ca;
      snp_valid = sv; snp_cmd = sc; snp_addr = sa;
      bus_done = bd; bus_shared_in = bs;
      #1;
      si = int'(sa[IW-1:0]); ci = int'(ca[IW-1:0]);
      s_st = m_st[si]; c_st = m_st[ci];
      s_hit = sv && s_st != 2'd0 && m_tag[si] == sa[AW-1:IW];
      e_sh = s_hit && sc == 2'd0;
      e_fl = s_hit && s_st == 2'd3 && sc != 2'd2;
      c_hit = c_st != 2'd0 && m_tag[ci] == ca[AW-1:IW];
      ok = c_hit && (!cw || c_st[1]);
      e_done = !m_busy && cv && !sv && ok;
      chk(ctx != "" ? ctx : "R6", "snp_shared", int'(snp_shared), int'(e_sh));
      chk(ctx != "" ? ctx : (sc == 2'd0 ? "R5" : "R7"), "snp_flush", int'(snp_flush), int'(e_fl));
      chk(ctx != "" ? ctx : (sv ? "R9" : "R3"), "cpu_done", int'(cpu_done), int'(e_done));
      chk(ctx != "" ? ctx : "R10", "cpu_hit", int'(cpu_hit), int'(e_done && !m_used));
      chk(ctx != "" ? ctx : "R12", "bus_valid", int'(bus_valid), int'(m_busy));
      if (m_busy) begin
         chk(bus_tag(m_cmd), "bus_cmd", int'(bus_cmd), int'(m_cmd));
         chk(bus_tag(m_cmd), "bus_addr", int'(bus_addr), int'(m_addr));
      end
      // advance model
      if (s_hit && sc == 2'd0) m_st[si] = 2'd1;
      if (s_hit && sc == 2'd1) m_st[si] = 2'd0;
      if (m_busy && bd) begin
         m_busy = 0;
         m_tag[int'(m_addr[IW-1:0])] = m_addr[AW-1:IW];
         m_st[int'(m_addr[IW-1:0])] = (m_cmd == 2'd2) ? 2'd0 :
                                      (m_cmd == 2'd1) ? 2'd3 : (bs ? 2'd1 : 2'd2);
      end else if (e_done) begin
         if (cw) m_st[ci] = 2'd3;
         m_used = 0;
      end else if (!m_busy && cv && !sv) begin
         m_busy = 1; m_used = 1;
         if (!c_hit && c_st == 2'd3) begin
            m_cmd = 2'd2; m_addr = {m_tag[ci], ca[IW-1:0]};
         end else begin
            m_cmd = cw ? 2'd1 : 2'd0; m_addr = ca;
         end
      end
      if (e_done) op_act = 0;
   endtask

   // runs one processor access to completion, bus answering at once
   task automatic run_op(input logic w, input logic [AW-1:0] a, input logic sh, input string ctx);
      op_act = 1;
      for (int k = 0; k < 12 && op_act; k++)
         step(1'b1, w, a, 1'b0, 2'd0, '0, m_busy, sh, ctx);
      step(1'b0, 1'b0, '0, 1'b0, 2'd0, '0, 1'b0, 1'b0, ctx);
   endtask

   task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input string ctx);
      step(1'b0, 1'b0, '0, 1'b1, c, a, 1'b0, 1'b0, ctx);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NL; i++) begin m_st[i] = 2'd0; m_tag[i] = '0; end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: nothing held after reset
      snoop(2'd0, 6'h05, "R1");
      snoop(2'd1, 6'h0A, "R1");
      // R2 read miss, shared low -> E; R3 write to E is local
      run_op(1'b0, 6'h01, 1'b0, "");
      run_op(1'b1, 6'h01, 1'b0, "");
      // R5 snoop read hits M: flush, -> S
      snoop(2'd0, 6'h01, "");
      // R4 write to S issues read-for-ownership
      run_op(1'b1, 6'h01, 1'b0, "");
      // R11 snooped write-back ignored, line still M
      snoop(2'd2, 6'h01, "R11");
      snoop(2'd0, 6'h01, "R11");
      run_op(1'b1, 6'h01, 1'b1, "");
      // R8 dirty victim written back before refill
      run_op(1'b0, 6'h05, 1'b1, "");
      // R6 snoop read on S, R7 snoop ownership invalidates
      snoop(2'd0, 6'h05, "");
      snoop(2'd1, 6'h05, "");
      // R6 E -> S without flush
      run_op(1'b0, 6'h02, 1'b0, "");
      snoop(2'd0, 6'h02, "");
      // R9 snoop in the same cycle as a request
      op_act = 1;
      step(1'b1, 1'b0, 6'h02, 1'b1, 2'd1, 6'h02, 1'b0, 1'b0, "R9");
      for (int k = 0; k < 12 && op_act; k++)
         step(1'b1, 1'b0, 6'h02, 1'b0, 2'd0, '0, m_busy, 1'b0, "");
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic bd, sv;
         if (!op_act && ($urandom % 3) != 0) begin
            op_act = 1; op_w = 1'($urandom); op_a = AW'($urandom % 16);
         end
         bd = m_busy && ($urandom % 2 == 0);
         sv = !bd && ($urandom % 10 < 3);
         step(op_act, op_w, op_a, sv, 2'($urandom % 3), AW'($urandom % 16),
              bd, 1'($urandom), "");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule